// File: doc/BRIEF.md
# Byte-Lane Bus Cycle Decoder Target

This block sits on a 32-bit processor bus as a target. Each bus cycle is opened by a single-cycle address strobe. At that strobe the block takes in a word address, four byte-lane enables, the write data, and three cycle-definition lines. It then serves the cycle from one of two small internal stores: a memory space and a separate I/O space. A one-cycle ready pulse answers the cycle on the next clock.

Byte lanes are honoured in both directions. A write changes only the bytes whose enable is set. A read drives zero on every lane whose enable is clear. A cycle whose data/control line is low is a control cycle and touches neither store. When such a cycle carries all four enables, it latches a shutdown indication that holds until reset.

A small combinational helper is also exposed on the same top. From the two low address bits and a transfer-size code, it produces the matching byte-enable pattern, so a bus master can drive the lanes correctly.

Top module: `bus_lane_target`

## Requirements
- R1: A strobe (`ads` high for one clock) is answered by `ready` high for exactly one clock, in the clock cycle right after the strobe. `ready` is never high without a strobe in the cycle before.
- R2: A memory or I/O data write (`wr_nrd`=1, `data_nctl`=1) updates only the bytes whose enable is set. Enable bit i covers data bits 8i+7..8i, so bit 0 covers bits 7..0 and bit 3 covers bits 31..24.
- R3: On a data read (`wr_nrd`=0, `data_nctl`=1), `rdata` shows the stored bytes on enabled lanes and zero on disabled lanes. `rdata` is zero whenever `ready` is low.
- R4: `mem_nio`=1 selects the 256-word memory space and `mem_nio`=0 selects the 16-word I/O space. The two spaces are independent, even at the same index.
- R5: The memory space is indexed by `addr_word[7:0]` and the I/O space by `addr_word[3:0]`. Higher address bits are ignored, so addresses that differ only in those bits alias.
- R6: A control cycle (`data_nctl`=0) changes no stored byte, returns `rdata` of zero, and is still answered by `ready`.
- R7: A control cycle with `byte_en`=4'b1111 sets `shutdown` one clock after the strobe, and `shutdown` stays set until reset. A control cycle with fewer enables leaves `shutdown` unchanged.
- R8: Synchronous active-high `rst` clears every stored byte in both spaces, clears `shutdown`, and holds `ready` low.
- R9: The helper output `gen_be` is a run of (`gen_size`+1) set bits starting at bit `gen_low`, with any bits beyond lane 3 dropped. For example, size code 0 with `gen_low`=2 gives 4'b0100, size code 3 with `gen_low`=0 gives 4'b1111, and size code 3 with `gen_low`=2 gives 4'b1100.
- R10: A data write cycle returns `rdata` of zero during its `ready` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ads | input | 1 | Single-cycle address strobe that opens a bus cycle |
| addr_word | input | 30 | Word address (address bits 31..2) |
| byte_en | input | 4 | Byte-lane enables, bit i covers data byte i |
| wr_nrd | input | 1 | 1 = write cycle, 0 = read cycle |
| mem_nio | input | 1 | 1 = memory space, 0 = I/O space |
| data_nctl | input | 1 | 1 = data transfer, 0 = control cycle |
| wdata | input | 32 | Write data, sampled with the strobe |
| rdata | output | 32 | Read data, valid while ready is high |
| ready | output | 1 | One-cycle cycle-completion pulse |
| shutdown | output | 1 | Sticky shutdown indication |
| gen_low | input | 2 | Helper: low two address bits |
| gen_size | input | 2 | Helper: transfer size code, bytes minus one |
| gen_be | output | 4 | Helper: generated byte-enable pattern |

## Verification
The bench goes after partial-lane writes over known data. A design that ignored enables would overwrite neighbouring bytes, and this shows up on a later full-width read. It also reads with sparse enables, where a design that skipped lane masking would leak stored bytes onto disabled lanes. The same index is used in both spaces and through high address bits that should alias, which catches a swapped space select or a wrong index width. Control cycles are issued with both partial and full enables and as writes. A design that let them write, returned data, or set shutdown on partial enables would disagree with the model. The reset path and the helper's truncation at the top lane are checked as well.

// File: rtl/bus_tgt_pkg.sv
package bus_tgt_pkg;
  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_MEM  = 2'd1,
    CYC_IO   = 2'd2,
    CYC_CTL  = 2'd3
  } cyc_kind_t;
endpackage

// File: rtl/lane_be_gen.sv
module lane_be_gen #(
  parameter int NL = 4
) (
  input  logic [$clog2(NL)-1:0] low_addr,
  input  logic [$clog2(NL)-1:0] size_code,
  output logic [NL-1:0]         be
);
  logic [NL-1:0]   run_mask;
  logic [2*NL-1:0] shifted;

  always_comb begin
    run_mask = '0;
    for (int i = 0; i < NL; i++) begin
      if (i <= int'(size_code)) run_mask[i] = 1'b1;
    end
    shifted = {{NL{1'b0}}, run_mask} << low_addr;
    be = shifted[NL-1:0];
  end
endmodule

// File: rtl/cycle_decode.sv
module cycle_decode
  import bus_tgt_pkg::*;
#(
  parameter int NL = 4
) (
  input  logic          ads,
  input  logic          wr_nrd,
  input  logic          mem_nio,
  input  logic          data_nctl,
  input  logic [NL-1:0] byte_en,
  output cyc_kind_t     kind,
  output logic [NL-1:0] mem_we,
  output logic [NL-1:0] io_we,
  output logic [NL-1:0] rd_lanes,
  output logic          shut_hit
);
  always_comb begin
    kind = CYC_NONE;
    if (ads) begin
      if (!data_nctl)   kind = CYC_CTL;
      else if (mem_nio) kind = CYC_MEM;
      else              kind = CYC_IO;
    end
    mem_we   = (kind == CYC_MEM && wr_nrd) ? byte_en : '0;
    io_we    = (kind == CYC_IO  && wr_nrd) ? byte_en : '0;
    rd_lanes = ((kind == CYC_MEM || kind == CYC_IO) && !wr_nrd) ? byte_en : '0;
    shut_hit = (kind == CYC_CTL) && (&byte_en);
  end
endmodule

// File: rtl/lane_ram.sv
module lane_ram #(
  parameter int DEPTH = 256,
  parameter int NL    = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic [NL-1:0]   we,
  input  logic [NL*8-1:0] wdata,
  output logic [NL*8-1:0] rdata
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [7:0] store [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) store[i] <= 8'h00;
        rd_q <= 8'h00;
      end else begin
        if (we[l]) store[addr] <= wdata[l*8 +: 8];
        rd_q <= store[addr];
      end
    end

    assign rdata[l*8 +: 8] = rd_q;
  end
endmodule

// File: rtl/bus_lane_target.sv
module bus_lane_target
  import bus_tgt_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 30,
  parameter int MEM_WORDS = 256,
  parameter int IO_WORDS  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ads,
  input  logic [AW-1:0]            addr_word,
  input  logic [DW/8-1:0]          byte_en,
  input  logic                     wr_nrd,
  input  logic                     mem_nio,
  input  logic                     data_nctl,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic                     ready,
  output logic                     shutdown,
  input  logic [$clog2(DW/8)-1:0]  gen_low,
  input  logic [$clog2(DW/8)-1:0]  gen_size,
  output logic [DW/8-1:0]          gen_be
);
  localparam int NL  = DW / 8;
  localparam int MAW = $clog2(MEM_WORDS);
  localparam int IAW = $clog2(IO_WORDS);

  cyc_kind_t     kind;
  logic [NL-1:0] mem_we, io_we, rd_lanes;
  logic          shut_hit;
  logic [DW-1:0] mem_rd, io_rd;
  logic          ready_q, shutdown_q, sel_io_q;
  logic [NL-1:0] lane_q;
  logic [DW-1:0] lane_bits;

  cycle_decode #(.NL(NL)) u_dec (
    .ads       (ads),
    .wr_nrd    (wr_nrd),
    .mem_nio   (mem_nio),
    .data_nctl (data_nctl),
    .byte_en   (byte_en),
    .kind      (kind),
    .mem_we    (mem_we),
    .io_we     (io_we),
    .rd_lanes  (rd_lanes),
    .shut_hit  (shut_hit)
  );

  lane_ram #(.DEPTH(MEM_WORDS), .NL(NL)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr_word[MAW-1:0]),
    .we    (mem_we),
    .wdata (wdata),
    .rdata (mem_rd)
  );

  lane_ram #(.DEPTH(IO_WORDS), .NL(NL)) u_io (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr_word[IAW-1:0]),
    .we    (io_we),
    .wdata (wdata),
    .rdata (io_rd)
  );

  lane_be_gen #(.NL(NL)) u_begen (
    .low_addr  (gen_low),
    .size_code (gen_size),
    .be        (gen_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q    <= 1'b0;
      shutdown_q <= 1'b0;
      sel_io_q   <= 1'b0;
      lane_q     <= '0;
    end else begin
      ready_q  <= (kind != CYC_NONE);
      sel_io_q <= (kind == CYC_IO);
      lane_q   <= rd_lanes;
      if (shut_hit) shutdown_q <= 1'b1;
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_mask
    assign lane_bits[l*8 +: 8] = {8{lane_q[l]}};
  end

  assign rdata    = (sel_io_q ? io_rd : mem_rd) & lane_bits;
  assign ready    = ready_q;
  assign shutdown = shutdown_q;
endmodule

// File: rtl/bus_lane_target_chk.sv
module bus_lane_target_chk #(
  parameter int DW = 32,
  parameter int AW = 30
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ads,
  input logic [AW-1:0]           addr_word,
  input logic [DW/8-1:0]         byte_en,
  input logic                    wr_nrd,
  input logic                    mem_nio,
  input logic                    data_nctl,
  input logic [DW-1:0]           wdata,
  input logic [DW-1:0]           rdata,
  input logic                    ready,
  input logic                    shutdown,
  input logic [$clog2(DW/8)-1:0] gen_low,
  input logic [$clog2(DW/8)-1:0] gen_size,
  input logic [DW/8-1:0]         gen_be
);
  localparam int NL = DW / 8;

  logic [NL-1:0] be_seen;
  logic [DW-1:0] off_bits;

  always_ff @(posedge clk) begin
    if (rst) be_seen <= '0;
    else     be_seen <= byte_en;
  end

  always_comb begin
    for (int l = 0; l < NL; l++) off_bits[l*8 +: 8] = {8{~be_seen[l]}};
  end

  AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    ads |=> ready);  // R1
  AST_READY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    ready |-> $past(ads));  // R1
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (rdata == '0));  // R3
  AST_OFF_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
    ready |-> ((rdata & off_bits) == '0));  // R3
  AST_CTL_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (ads && !data_nctl) |=> (rdata == '0));  // R6
  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (ads && wr_nrd) |=> (rdata == '0));  // R10
  AST_SHUTDOWN_SET: assert property (@(posedge clk) disable iff (rst)
    (ads && !data_nctl && (&byte_en)) |=> shutdown);  // R7
  AST_SHUTDOWN_STICKY: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> shutdown);  // R7
  AST_GEN_SINGLE_BYTE: assert property (@(posedge clk) disable iff (rst)
    (gen_size == '0) |-> ($countones(gen_be) == 1));  // R9
endmodule

bind bus_lane_target bus_lane_target_chk #(.DW(DW), .AW(AW)) i_chk (.*);

// File: tb/test_bus_lane_target.sv
module test_bus_lane_target;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ads = 1'b0;
  logic [29:0] addr_word = '0;
  logic [3:0]  byte_en = '0;
  logic        wr_nrd = 1'b0;
  logic        mem_nio = 1'b1;
  logic        data_nctl = 1'b1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready;
  logic        shutdown;
  logic [1:0]  gen_low = '0;
  logic [1:0]  gen_size = '0;
  logic [3:0]  gen_be;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] mem_model [256];
  logic [31:0] io_model  [16];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_lane_target i_bus_lane_target (.*);

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int l = 0; l < 4; l++) m[l*8 +: 8] = {8{be[l]}};
    return m;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 256; i++) mem_model[i] = '0;
    for (int i = 0; i < 16; i++)  io_model[i]  = '0;
  endtask

  // driver: compute expectation, push to scoreboard, drive one strobe
  task automatic bus_cycle(input logic w, input logic m, input logic d,
                           input logic [29:0] a, input logic [3:0] be,
                           input logic [31:0] wd, input string tag);
    logic [31:0] exp;
    logic [31:0] mk;
    exp = '0;
    mk  = lane_mask(be);
    if (d && !w) exp = (m ? mem_model[a[7:0]] : io_model[a[3:0]]) & mk;
    if (d && w) begin
      if (m) mem_model[a[7:0]] = (mem_model[a[7:0]] & ~mk) | (wd & mk);
      else   io_model[a[3:0]]  = (io_model[a[3:0]]  & ~mk) | (wd & mk);
    end
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    ads = 1'b1; wr_nrd = w; mem_nio = m; data_nctl = d;
    addr_word = a; byte_en = be; wdata = wd;
    @(negedge clk);
    ads = 1'b0; wdata = 32'hDEAD_BEEF; byte_en = 4'h0;
    @(negedge clk);
  endtask

  // monitor: pop and compare on each ready pulse
  always @(negedge clk) begin
    if (!rst && ready) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R1: ready without pending cycle, actual 1 expected 0");
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  function automatic logic [3:0] gen_model(input int low, input int sz);
    logic [7:0] w;
    w = 8'((1 << (sz + 1)) - 1) << low;
    return w[3:0];
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    model_clear();
    repeat (3) @(negedge clk);
    check("R8 ready in reset", {31'b0, ready}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 ready after reset", {31'b0, ready}, 32'h0);
    check("R8 shutdown after reset", {31'b0, shutdown}, 32'h0);
    check("R3 idle rdata", rdata, 32'h0);
    bus_cycle(0, 1, 1, 30'h10, 4'hF, 0, "R8 mem cleared");

    // full writes and reads, R2/R4
    bus_cycle(1, 1, 1, 30'h05, 4'hF, 32'h1122_3344, "R10 write data zero");
    bus_cycle(1, 0, 1, 30'h05, 4'hF, 32'hAABB_CCDD, "R10 io write data zero");
    bus_cycle(0, 1, 1, 30'h05, 4'hF, 0, "R4 mem word");
    bus_cycle(0, 0, 1, 30'h05, 4'hF, 0, "R4 io word");

    // partial writes R2
    bus_cycle(1, 1, 1, 30'h05, 4'b0100, 32'h55EE_6677, "R2 lane2 write");
    bus_cycle(1, 1, 1, 30'h05, 4'b0001, 32'h0000_0099, "R2 lane0 write");
    bus_cycle(0, 1, 1, 30'h05, 4'hF, 0, "R2 merged word");
    bus_cycle(1, 0, 1, 30'h07, 4'b1100, 32'h1357_9BDF, "R2 io upper write");
    bus_cycle(0, 0, 1, 30'h07, 4'hF, 0, "R2 io upper read");

    // sparse reads R3
    bus_cycle(0, 1, 1, 30'h05, 4'b1010, 0, "R3 sparse read");
    bus_cycle(0, 1, 1, 30'h05, 4'b0000, 0, "R3 no lanes");
    bus_cycle(0, 0, 1, 30'h05, 4'b0011, 0, "R3 io low half");

    // aliasing R5
    bus_cycle(1, 1, 1, 30'h3FF_FF03, 4'hF, 32'hCAFE_F00D, "R5 high-bit write");
    bus_cycle(0, 1, 1, 30'h103, 4'hF, 0, "R5 mem alias");
    bus_cycle(1, 0, 1, 30'h23, 4'hF, 32'h0BAD_1DEA, "R5 io high write");
    bus_cycle(0, 0, 1, 30'h13, 4'hF, 0, "R5 io alias");
    bus_cycle(0, 1, 1, 30'h03, 4'hF, 0, "R4 mem unaffected by io");

    // control cycles R6/R7
    bus_cycle(1, 1, 0, 30'h05, 4'b0011, 32'hFFFF_FFFF, "R6 ctl write no data");
    check("R7 partial ctl no shutdown", {31'b0, shutdown}, 32'h0);
    bus_cycle(0, 1, 1, 30'h05, 4'hF, 0, "R6 mem unchanged by ctl");
    bus_cycle(0, 0, 0, 30'h05, 4'hF, 0, "R6 ctl read zero");
    check("R7 shutdown set", {31'b0, shutdown}, 32'h1);
    bus_cycle(0, 1, 1, 30'h05, 4'hF, 0, "R6 mem after full ctl");
    check("R7 shutdown sticky", {31'b0, shutdown}, 32'h1);

    // helper R9
    for (int lo = 0; lo < 4; lo++) begin
      for (int sz = 0; sz < 4; sz++) begin
        gen_low = 2'(lo); gen_size = 2'(sz);
        #1;
        check($sformatf("R9 gen low=%0d size=%0d", lo, sz), {28'b0, gen_be},
              {28'b0, gen_model(lo, sz)});
      end
    end

    // reset clears R8
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
    check("R8 shutdown cleared", {31'b0, shutdown}, 32'h0);
    bus_cycle(0, 1, 1, 30'h05, 4'hF, 0, "R8 mem word cleared");
    bus_cycle(0, 0, 1, 30'h07, 4'hF, 0, "R8 io word cleared");

    repeat (3) @(negedge clk);
    check("R1 all cycles answered", 32'(exp_q.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule